// File: doc/BRIEF.md
# Asynchronous Strobe FIFO Write Endpoint

This block receives bytes from an external master over unclocked, active-low strobes and stores them in one of four endpoint byte buffers. The strobes, chip select and packet-end line are brought into the system clock domain through two-flop synchronizers. A small write-strobe state machine watches the synchronized copies and recognizes a write only when chip select was active as the strobe went low. The byte and the buffer address are taken from the bus while the strobe is held low. They are stored when the strobe is released, and the buffer's write pointer then advances.

A packet-end strobe commits the bytes written to the addressed buffer since its previous commit, even a short or empty packet. The block then reports the committed length and a committed flag for that buffer. Per-buffer empty, full and sticky overflow flags are provided, together with a sticky protocol-error flag for overlapping strobes. The host side drains the buffers through a simple show-ahead read port.

Write-strobe state machine: `W_IDLE` (strobe high) goes to `W_ARMED` when the strobe falls with chip select active, and to `W_REJECT` when it falls with chip select inactive. `W_ARMED` returns to `W_IDLE` on release, issuing one write. `W_REJECT` returns to `W_IDLE` on release and issues nothing.

Top module: `afw_write_ep`

## Requirements
- R1: A write strobe whose falling edge is seen while chip select (active low) is inactive stores no byte: the addressed buffer's empty flag stays 1.
- R2: The stored byte is the value on the data bus during the last synchronized-low cycles of the strobe, not the value present when the strobe fell. While the strobe is held low, nothing is stored.
- R3: Each buffer is first-in first-out: the write pointer advances after each store, and bytes are read back in the order written.
- R4: The empty and full flags of a buffer change only after the write strobe is released, within 5 clock cycles of the release.
- R5: The 2-bit address (0 to 3) selects one of four independent buffers. A write changes only the selected buffer's flags.
- R6: A buffer holds 16 bytes, and full is 1 when it holds 16. A write to a full buffer is dropped, leaves the stored bytes unchanged, and sets that buffer's sticky overflow flag only.
- R7: A falling packet-end strobe (active low) sets the addressed buffer's committed flag. Its committed length (bits [5i+4:5i] of `commit_len` for buffer i) becomes the number of bytes written since that buffer's previous commit, and the pending count restarts at zero.
- R8: A packet-end with no bytes written since the previous commit commits a zero-length packet: committed flag 1, length 0.
- R9: If the write strobe and packet-end are both low in the same synchronized cycle, the sticky `proto_err` flag goes to 1, and a packet-end falling in that state is ignored.
- R10: `rd_data` shows the oldest byte of the buffer chosen by `rd_sel`. A cycle with `rd_en` high removes that byte and clears the buffer's committed flag.
- R11: After reset all buffers are empty, and no full, committed, overflow or protocol-error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Unclocked write strobe, active low |
| cs_n | input | 1 | Unclocked chip select, active low |
| ep_addr | input | 2 | Buffer address for writes and packet-end |
| wr_data | input | 8 | Write data bus |
| pkt_end_n | input | 1 | Unclocked packet-end strobe, active low |
| rd_en | input | 1 | Host pop of one byte from the selected buffer |
| rd_sel | input | 2 | Host read buffer select |
| rd_data | output | 8 | Oldest byte of the selected buffer |
| empty | output | 4 | Per-buffer empty flag |
| full | output | 4 | Per-buffer full flag |
| committed | output | 4 | Per-buffer packet-committed flag |
| commit_len | output | 20 | Per-buffer committed length, 5 bits each |
| overflow | output | 4 | Per-buffer sticky overflow flag |
| proto_err | output | 1 | Sticky overlapping-strobe flag |

## Verification
The assertions assume that each strobe stays at each level for at least three clocks. They also assume that data and address are stable from three clocks before a write-strobe release until two clocks after it, and that the address is held while packet-end is low. The directed tasks hold every strobe level for four or more clocks and change the bus only while the write strobe has been low for several cycles. The overlap scenario is the one place where the two strobes are driven low together on purpose.

// File: rtl/afw_pkg.sv
package afw_pkg;
    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_ARMED  = 2'd1,
        W_REJECT = 2'd2
    } wr_state_t;
endpackage

// File: rtl/afw_sync.sv
module afw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/afw_strobe_fsm.sv
module afw_strobe_fsm
    import afw_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_s,
    input  logic          cs_s,
    input  logic          pe_s,
    input  logic [SW-1:0] addr_raw,
    input  logic [DW-1:0] data_raw,
    output logic          wr_pulse,
    output logic          commit_pulse,
    output logic [SW-1:0] wr_addr,
    output logic [DW-1:0] wr_byte,
    output logic [SW-1:0] pe_addr,
    output logic          proto_err
);
    wr_state_t state, state_nxt;
    logic      pe_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            W_IDLE:   if (!wr_s) state_nxt = cs_s ? W_REJECT : W_ARMED;
            W_ARMED:  if (wr_s)  state_nxt = W_IDLE;
            W_REJECT: if (wr_s)  state_nxt = W_IDLE;
            default:             state_nxt = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_pulse = 1'b0;
        unique case (state)
            W_ARMED: wr_pulse = wr_s;
            default: wr_pulse = 1'b0;
        endcase
    end

    // bus capture while the synchronized strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_byte <= '0;
        end else if (!wr_s) begin
            wr_addr <= addr_raw;
            wr_byte <= data_raw;
        end
    end

    // packet-end edge and overlap detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe_q      <= 1'b1;
            proto_err <= 1'b0;
        end else begin
            pe_q <= pe_s;
            if (!wr_s && !pe_s) proto_err <= 1'b1;
        end
    end

    assign commit_pulse = pe_q && !pe_s && wr_s;
    assign pe_addr      = addr_raw;

    AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R9
    AST_PROTO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_s && !pe_s) |=> proto_err); // R9
    AST_NO_PULSE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_s |-> !wr_pulse); // R2
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_IDLE && !wr_s && cs_s) |=> !wr_pulse); // R1
endmodule

// File: rtl/afw_buffer.sv
module afw_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          commit,
    input  logic          re,
    output logic [DW-1:0] head,
    output logic          is_empty,
    output logic          is_full,
    output logic          is_committed,
    output logic [CW-1:0] clen,
    output logic          ovf
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count, pend;
    logic          do_wr, do_rd;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign do_wr    = we && !is_full;
    assign do_rd    = re && !is_empty;
    assign head     = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr         <= '0;
            rptr         <= '0;
            count        <= '0;
            pend         <= '0;
            clen         <= '0;
            is_committed <= 1'b0;
            ovf          <= 1'b0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
            if (we && is_full) ovf <= 1'b1;
            if (commit) begin
                clen <= pend;
                pend <= '0;
            end else if (do_wr) begin
                pend <= pend + 1'b1;
            end
            if (commit)     is_committed <= 1'b1;
            else if (do_rd) is_committed <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (we && is_full && !re) |=> (ovf && is_full && $stable(wptr))); // R6
    AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !is_full && !re) |=> (count == $past(count) + 1'b1)); // R3
    AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (is_committed && pend == '0)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R6
endmodule

// File: rtl/afw_write_ep.sv
module afw_write_ep #(
    parameter int NBUF  = 4,
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int SW   = $clog2(NBUF),
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             cs_n,
    input  logic [SW-1:0]    ep_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             pkt_end_n,
    input  logic             rd_en,
    input  logic [SW-1:0]    rd_sel,
    output logic [DW-1:0]    rd_data,
    output logic [NBUF-1:0]  empty,
    output logic [NBUF-1:0]  full,
    output logic [NBUF-1:0]  committed,
    output logic [NBUF*LW-1:0] commit_len,
    output logic [NBUF-1:0]  overflow,
    output logic             proto_err
);
    logic [2:0]    strobes_s;
    logic          wr_pulse, commit_pulse;
    logic [SW-1:0] wr_addr, pe_addr;
    logic [DW-1:0] wr_byte;
    logic [DW-1:0] heads [NBUF];

    afw_sync #(.WIDTH(3), .STAGES(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pkt_end_n, cs_n, wr_n}),
        .sync_out (strobes_s)
    );

    afw_strobe_fsm #(.DW(DW), .SW(SW)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_s         (strobes_s[0]),
        .cs_s         (strobes_s[1]),
        .pe_s         (strobes_s[2]),
        .addr_raw     (ep_addr),
        .data_raw     (wr_data),
        .wr_pulse     (wr_pulse),
        .commit_pulse (commit_pulse),
        .wr_addr      (wr_addr),
        .wr_byte      (wr_byte),
        .pe_addr      (pe_addr),
        .proto_err    (proto_err)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        afw_buffer #(.DW(DW), .DEPTH(DEPTH)) i_buf (
            .clk          (clk),
            .rst_n        (rst_n),
            .we           (wr_pulse && wr_addr == SW'(g)),
            .wdata        (wr_byte),
            .commit       (commit_pulse && pe_addr == SW'(g)),
            .re           (rd_en && rd_sel == SW'(g)),
            .head         (heads[g]),
            .is_empty     (empty[g]),
            .is_full      (full[g]),
            .is_committed (committed[g]),
            .clen         (commit_len[g*LW +: LW]),
            .ovf          (overflow[g])
        );
    end

    assign rd_data = heads[rd_sel];

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && commit_pulse)); // R9
    AST_STORE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !rd_en) |=> !empty[$past(wr_addr)]); // R4
endmodule

// File: tb/test_afw_write_ep.sv
module test_afw_write_ep;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1, cs_n = 1'b1, pkt_end_n = 1'b1, rd_en = 1'b0;
    logic [1:0]  ep_addr = '0, rd_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  empty, full, committed, overflow;
    logic [19:0] commit_len;
    logic        proto_err;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    afw_write_ep i_afw_write_ep (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .ep_addr(ep_addr),
        .wr_data(wr_data), .pkt_end_n(pkt_end_n), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .empty(empty), .full(full), .committed(committed),
        .commit_len(commit_len), .overflow(overflow), .proto_err(proto_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [1:0] a, input logic [7:0] d);
        ep_addr = a; wr_data = d;
        wr_n = 1'b0; wait_n(4);
        wr_n = 1'b1; wait_n(5);
    endtask

    task automatic packet_end(input logic [1:0] a);
        ep_addr = a;
        pkt_end_n = 1'b0; wait_n(4);
        pkt_end_n = 1'b1; wait_n(5);
    endtask

    task automatic pop(input logic [1:0] s);
        rd_sel = s; rd_en = 1'b1; wait_n(1); rd_en = 1'b0;
    endtask

    function automatic int len_of(input int b);
        return int'(commit_len[b*5 +: 5]);
    endfunction

    task automatic t_reset;
        check("R11 empty", empty, 4'hF);
        check("R11 full", full, 0);
        check("R11 committed", committed, 0);
        check("R11 overflow", overflow, 0);
        check("R11 proto_err", proto_err, 0);
    endtask

    task automatic t_chip_select;
        cs_n = 1'b1;
        write_byte(2'd0, 8'h11);
        check("R1 no store without cs", empty[0], 1);
        cs_n = 1'b0; wait_n(4);
    endtask

    task automatic t_release_edge;
        ep_addr = 2'd0; wr_data = 8'h33;
        wr_n = 1'b0; wait_n(8);
        check("R2 nothing stored while low", empty[0], 1);
        wr_data = 8'h5A; wait_n(4);
        wr_n = 1'b1; wait_n(1);
        check("R4 flag not yet updated", empty[0], 1);
        wait_n(4);
        check("R4 flag updated after release", empty[0], 0);
        rd_sel = 2'd0; wait_n(1);
        check("R2 last bus value stored", rd_data, 8'h5A);
        pop(2'd0);
        check("R10 pop empties buf0", empty[0], 1);
    endtask

    task automatic t_order;
        write_byte(2'd1, 8'hA1);
        write_byte(2'd1, 8'hA2);
        write_byte(2'd1, 8'hA3);
        rd_sel = 2'd1; wait_n(1);
        check("R3 first", rd_data, 8'hA1); pop(2'd1);
        check("R3 second", rd_data, 8'hA2); pop(2'd1);
        check("R3 third", rd_data, 8'hA3); pop(2'd1);
        check("R10 buf1 drained", empty[1], 1);
    endtask

    task automatic t_isolation;
        write_byte(2'd2, 8'h01);
        check("R5 buf2 written", empty[2], 0);
        check("R5 others untouched", {empty[3], empty[1], empty[0]}, 3'b111);
    endtask

    task automatic t_commit;
        write_byte(2'd2, 8'h02);
        write_byte(2'd2, 8'h03);
        write_byte(2'd2, 8'h04);
        check("R7 not committed before strobe", committed[2], 0);
        packet_end(2'd2);
        check("R7 committed flag", committed[2], 1);
        check("R7 short packet length 4", len_of(2), 4);
        write_byte(2'd2, 8'h05);
        write_byte(2'd2, 8'h06);
        packet_end(2'd2);
        check("R7 second packet length 2", len_of(2), 2);
        check("R7 other buffers not committed", committed[1:0], 0);
    endtask

    task automatic t_zero_length;
        packet_end(2'd1);
        check("R8 pending bytes of buf1", len_of(1), 3);
        packet_end(2'd1);
        check("R8 zero-length committed", committed[1], 1);
        check("R8 zero length", len_of(1), 0);
    endtask

    task automatic t_read_clears;
        rd_sel = 2'd2; wait_n(1);
        check("R10 head of buf2", rd_data, 8'h01);
        pop(2'd2);
        check("R10 committed cleared by read", committed[2], 0);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 16; i++) write_byte(2'd3, 8'(8'h40 + i));
        check("R6 full at 16", full[3], 1);
        check("R6 no overflow yet", overflow[3], 0);
        write_byte(2'd3, 8'hEE);
        check("R6 overflow set", overflow[3], 1);
        check("R6 overflow only buf3", overflow[2:0], 0);
        check("R6 still full", full[3], 1);
        rd_sel = 2'd3; wait_n(1);
        check("R6 oldest byte kept", rd_data, 8'h40);
        for (int i = 0; i < 16; i++) pop(2'd3);
        check("R6 dropped byte absent", empty[3], 1);
        check("R6 overflow sticky", overflow[3], 1);
    endtask

    task automatic t_overlap;
        ep_addr = 2'd0; wr_data = 8'h77;
        wr_n = 1'b0; wait_n(4);
        pkt_end_n = 1'b0; wait_n(4);
        pkt_end_n = 1'b1; wait_n(4);
        wr_n = 1'b1; wait_n(5);
        check("R9 proto_err raised", proto_err, 1);
        check("R9 packet-end ignored", committed[0], 0);
        wait_n(3);
        check("R9 proto_err sticky", proto_err, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_chip_select();
        t_release_edge();
        t_order();
        t_isolation();
        t_commit();
        t_zero_length();
        t_read_clears();
        t_overflow();
        t_overlap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule